// File: doc/BRIEF.md
# Keyboard Controller Host Command Processor

This block sits behind the host side of a PC-style keyboard and mouse controller. The host sees two byte-wide ports, selected by `wrIsCmd`: a data port and a command port. A byte written to the command port is decoded at once. It can change mode bits, queue a reply byte toward the host, move the A20 gate, request a CPU reset, or arm a one-shot redirect for the next byte written to the data port. A data byte goes to the keyboard unless a redirect is armed. An armed redirect sends it to the mode register, the output port, the keyboard or aux reply path, or the mouse.

The block keeps the mode, status and output-port registers. Reply bytes and forwarded bytes leave as single-cycle strobes, and the channels behind them queue those bytes. Two inputs report whether the keyboard or aux channel holds unread data. They drive the two interrupt lines and the buffer-full flags in the status byte. Every strobe and register update appears on the clock edge that samples the write.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After reset the mode is 0x03, the stored output port is 0x03 (`a20` = 1), status self-test bit 2 is 0, and the status byte reads 0x18 with no channel data.
- R2: Command 0x20 pushes the current mode byte on the keyboard reply path (`pushAux` = 0).
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm the next data-port write. 0x60 loads mode, 0xD1 loads the output port, 0xD2 pushes the byte as keyboard reply, 0xD3 pushes it as aux reply, and 0xD4 forwards it to the mouse. With nothing armed, a data byte is forwarded to the keyboard.
- R4: Every data-port write disarms the redirect, so the following data byte goes to the keyboard.
- R5: `translateEn` follows mode bit 6 and changes only when mode is written.
- R6: Command 0xAA sets status bit 2 and pushes 0x55. Commands 0xA9 and 0xAB push 0x00. Command 0xC0 pushes 0x80. Command 0xD0 pushes the output port with bit 4 replaced by "any channel has data" and bit 5 replaced by "only aux has data".
- R7: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4, which gates `irqKbd` on the next cycle.
- R8: Command 0xDF sets output-port bit 1 and drives `a20` high. Command 0xDD clears the bit and drives it low.
- R9: A data byte loaded into the output port drives `a20` from its bit 1. If its bit 0 is 0, it also gives a one-cycle `resetReq` in the same cycle as the `a20` change.
- R10: A command byte with upper nibble 0xF pulses `resetReq` when its bit 0 is 0. When bit 0 is 1 it does nothing.
- R11: `irqKbd` = keyboard data & mode bit 0 & !mode bit 4. `irqAux` = aux data & no keyboard data & mode bit 1. Status bit 0 = any data, and status bit 5 = only aux data.
- R12: An unrecognised command byte pulses `badCmd` for one cycle. It changes no register and leaves an armed redirect armed.
- R13: Each write causes at most one of push, keyboard forward, mouse forward, reset request and bad-command. Each of these lasts one cycle, in the cycle after the write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Host write strobe |
| wrIsCmd | input | 1 | 1 selects the command port, 0 selects the data port |
| wrByte | input | 8 | Written byte |
| kbdHasData | input | 1 | Keyboard channel holds unread data |
| auxHasData | input | 1 | Aux channel holds unread data |
| pushValid | output | 1 | Reply byte push strobe |
| pushAux | output | 1 | Push target: 1 aux, 0 keyboard |
| pushByte | output | 8 | Pushed byte |
| kbdFwdValid | output | 1 | Byte forwarded to the keyboard |
| mouseFwdValid | output | 1 | Byte forwarded to the mouse |
| fwdByte | output | 8 | Forwarded byte |
| translateEn | output | 1 | Scan-code translation enable (mode bit 6) |
| a20 | output | 1 | A20 gate |
| resetReq | output | 1 | One-cycle CPU reset request |
| badCmd | output | 1 | One-cycle unrecognised-command strobe |
| irqKbd | output | 1 | Keyboard interrupt |
| irqAux | output | 1 | Aux interrupt |
| statusByte | output | 8 | Status register value |

## Verification
Loading the output port can move `a20` and raise `resetReq` in the same cycle. The bench writes 0x02 after 0xD1 and expects a reset event from the scoreboard together with `a20` = 1 at the same sample. A second same-cycle case is an armed redirect that survives a command. The bench arms 0xD2, issues an unknown command, and expects both the `badCmd` event and, one write later, the keyboard reply push. The interrupt priority is checked with both channels holding data: `irqAux` must stay low while keyboard data is present.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    PEND_NONE, PEND_MODE, PEND_OUTPORT, PEND_KBDBUF, PEND_AUXBUF, PEND_MOUSE
  } pend_e;

  typedef enum logic [1:0] {
    SRC_CONST, SRC_MODE, SRC_OUTPORT, SRC_DATA
  } pushSrc_e;

  typedef struct packed {
    logic     push;
    logic     pushAux;
    pushSrc_e src;
    byte_t    constByte;
    logic     loadMode;
    logic     setModeBits;
    logic     clrModeBits;
    byte_t    modeMask;
    logic     setSelfTest;
    logic     a20On;
    logic     a20Off;
    logic     loadOutport;
    logic     fwdKbd;
    logic     fwdMouse;
    logic     rstPulse;
    logic     badCmd;
  } ctlStrobe_t;

  localparam byte_t MODE_RESET = 8'h03;
  localparam byte_t OUT_RESET  = 8'h03;
  localparam int MODE_KIRQ = 0;
  localparam int MODE_AIRQ = 1;
  localparam int MODE_KDIS = 4;
  localparam int MODE_ADIS = 5;
  localparam int MODE_XLAT = 6;
  localparam int OUT_NRST  = 0;
  localparam int OUT_GATE  = 1;
endpackage

// File: rtl/kbc_ctl.sv
module kbc_ctl
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       wrIsCmd,
  input  byte_t      wrByte,
  output ctlStrobe_t st
);
  pend_e pendQ, pendD;
  byte_t cmd;

  // fold the pulse-command family onto reset or no-op
  always_comb begin
    cmd = wrByte;
    if (wrByte[BYTE_W-1 -: NIB_W] == {NIB_W{1'b1}})
      cmd = wrByte[0] ? 8'hFF : 8'hFE;
  end

  always_comb begin
    st    = '0;
    pendD = pendQ;
    if (wrValid && wrIsCmd) begin
      unique case (cmd)
        8'h20: begin st.push = 1'b1; st.src = SRC_MODE; end
        8'h60: pendD = PEND_MODE;
        8'hD1: pendD = PEND_OUTPORT;
        8'hD2: pendD = PEND_KBDBUF;
        8'hD3: pendD = PEND_AUXBUF;
        8'hD4: pendD = PEND_MOUSE;
        8'hA7: begin st.setModeBits = 1'b1; st.modeMask = 8'(1 << MODE_ADIS); end
        8'hA8: begin st.clrModeBits = 1'b1; st.modeMask = 8'(1 << MODE_ADIS); end
        8'hAD: begin st.setModeBits = 1'b1; st.modeMask = 8'(1 << MODE_KDIS); end
        8'hAE: begin st.clrModeBits = 1'b1; st.modeMask = 8'(1 << MODE_KDIS); end
        8'hA9, 8'hAB: begin st.push = 1'b1; st.src = SRC_CONST; st.constByte = 8'h00; end
        8'hAA: begin
          st.push = 1'b1; st.src = SRC_CONST; st.constByte = 8'h55;
          st.setSelfTest = 1'b1;
        end
        8'hC0: begin st.push = 1'b1; st.src = SRC_CONST; st.constByte = 8'h80; end
        8'hD0: begin st.push = 1'b1; st.src = SRC_OUTPORT; end
        8'hDF: st.a20On  = 1'b1;
        8'hDD: st.a20Off = 1'b1;
        8'hFE: st.rstPulse = 1'b1;
        8'hFF: ;
        default: st.badCmd = 1'b1;
      endcase
    end else if (wrValid) begin
      pendD = PEND_NONE;
      unique case (pendQ)
        PEND_MODE:    st.loadMode    = 1'b1;
        PEND_OUTPORT: st.loadOutport = 1'b1;
        PEND_KBDBUF:  begin st.push = 1'b1; st.src = SRC_DATA; end
        PEND_AUXBUF:  begin st.push = 1'b1; st.pushAux = 1'b1; st.src = SRC_DATA; end
        PEND_MOUSE:   st.fwdMouse = 1'b1;
        default:      st.fwdKbd   = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= PEND_NONE;
    else       pendQ <= pendD;
  end

  assert_disarm_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrIsCmd) |=> (pendQ == PEND_NONE));

  assert_arm_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrIsCmd && wrByte == 8'h60) |=> (pendQ == PEND_MODE));

  assert_bad_keeps_pend_R12: assert property (@(posedge clk) disable iff (!rstN)
    st.badCmd |=> (pendQ == $past(pendQ)));
endmodule

// File: rtl/kbc_dp.sv
module kbc_dp
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t st,
  input  byte_t      dataByte,
  input  logic       kbdHasData,
  input  logic       auxHasData,
  output logic       pushValid,
  output logic       pushAux,
  output byte_t      pushByte,
  output logic       kbdFwdValid,
  output logic       mouseFwdValid,
  output byte_t      fwdByte,
  output logic       translateEn,
  output logic       a20,
  output logic       resetReq,
  output logic       badCmd,
  output logic       irqKbd,
  output logic       irqAux,
  output byte_t      statusByte
);
  byte_t modeQ, outQ, outRead, pushNext;
  logic  selfTestQ, anyData, auxOnly;

  assign anyData = kbdHasData | auxHasData;
  assign auxOnly = auxHasData & ~kbdHasData;

  // buffer-full flags are live, stored bits 4 and 5 are replaced on read
  assign outRead = {outQ[7:6], auxOnly, anyData, outQ[3:0]};

  always_comb begin
    unique case (st.src)
      SRC_CONST:   pushNext = st.constByte;
      SRC_MODE:    pushNext = modeQ;
      SRC_OUTPORT: pushNext = outRead;
      default:     pushNext = dataByte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ         <= MODE_RESET;
      outQ          <= OUT_RESET;
      selfTestQ     <= 1'b0;
      pushValid     <= 1'b0;
      pushAux       <= 1'b0;
      pushByte      <= '0;
      kbdFwdValid   <= 1'b0;
      mouseFwdValid <= 1'b0;
      fwdByte       <= '0;
      resetReq      <= 1'b0;
      badCmd        <= 1'b0;
    end else begin
      if (st.loadMode)         modeQ <= dataByte;
      else if (st.setModeBits) modeQ <= modeQ | st.modeMask;
      else if (st.clrModeBits) modeQ <= modeQ & ~st.modeMask;

      if (st.loadOutport)  outQ           <= dataByte;
      else if (st.a20On)   outQ[OUT_GATE] <= 1'b1;
      else if (st.a20Off)  outQ[OUT_GATE] <= 1'b0;

      if (st.setSelfTest) selfTestQ <= 1'b1;

      pushValid     <= st.push;
      pushAux       <= st.pushAux;
      pushByte      <= st.push ? pushNext : pushByte;
      kbdFwdValid   <= st.fwdKbd;
      mouseFwdValid <= st.fwdMouse;
      fwdByte       <= (st.fwdKbd | st.fwdMouse) ? dataByte : fwdByte;
      resetReq      <= st.rstPulse | (st.loadOutport & ~dataByte[OUT_NRST]);
      badCmd        <= st.badCmd;
    end
  end

  assign translateEn = modeQ[MODE_XLAT];
  assign a20         = outQ[OUT_GATE];
  assign irqKbd      = kbdHasData & modeQ[MODE_KIRQ] & ~modeQ[MODE_KDIS];
  assign irqAux      = auxOnly & modeQ[MODE_AIRQ];
  assign statusByte  = {2'b00, auxOnly, 1'b1, 1'b1, selfTestQ, 1'b0, anyData};

  assert_mode_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.setModeBits && !st.loadMode) |=> ((modeQ & $past(st.modeMask)) == $past(st.modeMask)));

  assert_mode_clr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrModeBits && !st.loadMode) |=> ((modeQ & $past(st.modeMask)) == 8'h00));

  assert_selftest_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(selfTestQ) |-> selfTestQ);
endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       wrIsCmd,
  input  logic [7:0] wrByte,
  input  logic       kbdHasData,
  input  logic       auxHasData,
  output logic       pushValid,
  output logic       pushAux,
  output logic [7:0] pushByte,
  output logic       kbdFwdValid,
  output logic       mouseFwdValid,
  output logic [7:0] fwdByte,
  output logic       translateEn,
  output logic       a20,
  output logic       resetReq,
  output logic       badCmd,
  output logic       irqKbd,
  output logic       irqAux,
  output logic [7:0] statusByte
);
  ctlStrobe_t strobes;

  kbc_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIsCmd(wrIsCmd),
    .wrByte(wrByte), .st(strobes)
  );

  kbc_dp u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .dataByte(wrByte),
    .kbdHasData(kbdHasData), .auxHasData(auxHasData),
    .pushValid(pushValid), .pushAux(pushAux), .pushByte(pushByte),
    .kbdFwdValid(kbdFwdValid), .mouseFwdValid(mouseFwdValid), .fwdByte(fwdByte),
    .translateEn(translateEn), .a20(a20), .resetReq(resetReq), .badCmd(badCmd),
    .irqKbd(irqKbd), .irqAux(irqAux), .statusByte(statusByte)
  );

  assert_event_single_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pushValid, kbdFwdValid, mouseFwdValid, resetReq, badCmd}));

  assert_event_needs_write_R13: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid || kbdFwdValid || mouseFwdValid || resetReq || badCmd) |-> $past(wrValid));

  assert_a20_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrValid) |-> $stable(a20));

  assert_xlat_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrValid) |-> $stable(translateEn));

  assert_irq_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(irqKbd && irqAux));
endmodule

// File: tb/kbc_cmd_proc_bench.sv
module kbc_cmd_proc_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0, wrIsCmd = 1'b0;
  logic [7:0] wrByte = '0;
  logic kbdHasData = 1'b0, auxHasData = 1'b0;
  logic pushValid, pushAux, kbdFwdValid, mouseFwdValid;
  logic translateEn, a20, resetReq, badCmd, irqKbd, irqAux;
  logic [7:0] pushByte, fwdByte, statusByte;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // scoreboard: kind 0 kbd push, 1 aux push, 2 kbd fwd, 3 mouse fwd, 4 reset, 5 bad
  int         expKind[$];
  logic [7:0] expByte[$];
  string      expTag[$];

  always #4 clk = ~clk;

  kbc_cmd_proc u_kbc_cmd_proc (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIsCmd(wrIsCmd), .wrByte(wrByte),
    .kbdHasData(kbdHasData), .auxHasData(auxHasData),
    .pushValid(pushValid), .pushAux(pushAux), .pushByte(pushByte),
    .kbdFwdValid(kbdFwdValid), .mouseFwdValid(mouseFwdValid), .fwdByte(fwdByte),
    .translateEn(translateEn), .a20(a20), .resetReq(resetReq), .badCmd(badCmd),
    .irqKbd(irqKbd), .irqAux(irqAux), .statusByte(statusByte)
  );

  task automatic expectEv(input int kind, input logic [7:0] b, input string tag);
    expKind.push_back(kind); expByte.push_back(b); expTag.push_back(tag);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit isCmd, input logic [7:0] b);
    wrValid = 1'b1; wrIsCmd = isCmd; wrByte = b;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && (pushValid || kbdFwdValid || mouseFwdValid || resetReq || badCmd)) begin
      int k;
      logic [7:0] b;
      k = pushValid ? (pushAux ? 1 : 0) : kbdFwdValid ? 2 : mouseFwdValid ? 3 : resetReq ? 4 : 5;
      b = pushValid ? pushByte : (kbdFwdValid || mouseFwdValid) ? fwdByte : 8'h00;
      checks++;
      if (expKind.size() == 0) begin
        fails++;
        $display("FAIL R13 unexpected event actual kind=%0d byte=%02h expected none", k, b);
      end else begin
        int ek;
        logic [7:0] eb;
        string et;
        ek = expKind.pop_front(); eb = expByte.pop_front(); et = expTag.pop_front();
        if (ek != k || (ek < 4 && eb !== b)) begin
          fails++;
          $display("FAIL %s actual kind=%0d byte=%02h expected kind=%0d byte=%02h", et, k, b, ek, eb);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({7'b0, a20}, 8'h01, "R1 a20");
    chk({7'b0, translateEn}, 8'h00, "R1 xlat");
    chk(statusByte, 8'h18, "R1 status");
    chk({6'b0, irqKbd, irqAux}, 8'h00, "R1 irq");
    expectEv(0, 8'h03, "R1_R2 mode read"); wr(1, 8'h20);
    expectEv(0, 8'h03, "R1 outport read"); wr(1, 8'hD0);
    // R3 plain data to keyboard
    expectEv(2, 8'h5A, "R3 kbd fwd"); wr(0, 8'h5A);
    // R5 mode write
    wr(1, 8'h60); wr(0, 8'h47);
    chk({7'b0, translateEn}, 8'h01, "R5 xlat on");
    expectEv(0, 8'h47, "R2 mode readback"); wr(1, 8'h20);
    expectEv(2, 8'h11, "R4 disarmed"); wr(0, 8'h11);
    // R3 redirects
    wr(1, 8'hD2); expectEv(0, 8'h9C, "R3 kbd buf"); wr(0, 8'h9C);
    wr(1, 8'hD3); expectEv(1, 8'h3E, "R3 aux buf"); wr(0, 8'h3E);
    wr(1, 8'hD4); expectEv(3, 8'h77, "R3 mouse"); wr(0, 8'h77);
    // R6 replies
    expectEv(0, 8'h55, "R6 self test"); wr(1, 8'hAA);
    chk(statusByte, 8'h1C, "R6 status bit2");
    expectEv(0, 8'h00, "R6 A9"); wr(1, 8'hA9);
    expectEv(0, 8'h00, "R6 AB"); wr(1, 8'hAB);
    expectEv(0, 8'h80, "R6 C0"); wr(1, 8'hC0);
    // R7 mode bits
    wr(1, 8'hA7); expectEv(0, 8'h67, "R7 aux disable"); wr(1, 8'h20);
    wr(1, 8'hA8); expectEv(0, 8'h47, "R7 aux enable"); wr(1, 8'h20);
    kbdHasData = 1'b1; #1;
    chk({6'b0, irqKbd, irqAux}, 8'h02, "R11 kbd irq");
    wr(1, 8'hAD);
    chk({7'b0, irqKbd}, 8'h00, "R7 kbd disabled irq");
    chk(statusByte, 8'h1D, "R11 status kbd data");
    wr(1, 8'hAE);
    chk({7'b0, irqKbd}, 8'h01, "R7 kbd enabled irq");
    expectEv(0, 8'h13, "R6 outport obf"); wr(1, 8'hD0);
    auxHasData = 1'b1; #1;
    chk({7'b0, irqAux}, 8'h00, "R11 kbd priority");
    kbdHasData = 1'b0; #1;
    chk({6'b0, irqKbd, irqAux}, 8'h01, "R11 aux irq");
    chk(statusByte, 8'h3D, "R11 status aux only");
    expectEv(0, 8'h33, "R6 outport aux obf"); wr(1, 8'hD0);
    auxHasData = 1'b0;
    // R8 A20 commands
    wr(1, 8'hDD);
    chk({7'b0, a20}, 8'h00, "R8 a20 off");
    expectEv(0, 8'h01, "R8 outport bit1 clear"); wr(1, 8'hD0);
    wr(1, 8'hDF);
    chk({7'b0, a20}, 8'h01, "R8 a20 on");
    // R9 output port writes
    wr(1, 8'hD1); wr(0, 8'h01);
    chk({7'b0, a20}, 8'h00, "R9 a20 from data");
    wr(1, 8'hD1); expectEv(4, 8'h00, "R9 reset with a20"); wr(0, 8'h02);
    chk({7'b0, a20}, 8'h01, "R9 a20 same cycle");
    wr(1, 8'hD1); wr(0, 8'h03);
    // R10 pulse folding
    expectEv(4, 8'h00, "R10 F0"); wr(1, 8'hF0);
    wr(1, 8'hF5);
    wr(1, 8'hFF);
    wr(1, 8'hF3);
    expectEv(4, 8'h00, "R10 FA"); wr(1, 8'hFA);
    expectEv(4, 8'h00, "R10 FE"); wr(1, 8'hFE);
    // R12 unknown command
    expectEv(5, 8'h00, "R12 bad"); wr(1, 8'h55);
    expectEv(0, 8'h47, "R12 mode unchanged"); wr(1, 8'h20);
    expectEv(0, 8'h03, "R12 outport unchanged"); wr(1, 8'hD0);
    wr(1, 8'hD2);
    expectEv(5, 8'h00, "R12 bad armed"); wr(1, 8'h12);
    expectEv(0, 8'h44, "R12 redirect kept"); wr(0, 8'h44);
    // R11 interrupts masked by mode
    wr(1, 8'h60); wr(0, 8'h00);
    chk({7'b0, translateEn}, 8'h00, "R5 xlat off");
    kbdHasData = 1'b1; auxHasData = 1'b0; #1;
    chk({7'b0, irqKbd}, 8'h00, "R11 kbd masked");
    kbdHasData = 1'b0; auxHasData = 1'b1; #1;
    chk({7'b0, irqAux}, 8'h00, "R11 aux masked");
    auxHasData = 1'b0;
    repeat (2) @(negedge clk);
    chk(8'(expKind.size()), 8'h00, "R13 events outstanding");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule